// File: doc/BRIEF.md
# Synchronous Master Shift Port

This block is a half-duplex synchronous serial engine that always acts as the master. It moves eight-bit words over a single bidirectional data line and drives the shift clock itself in both directions. A slave device, such as an external shift register, follows that clock. It shifts data out when sending and presents data when the master is receiving.

A transmit is started by writing a byte while the engine is idle. A receive is started by the engine itself whenever receive is enabled and the previous received byte has been acknowledged. At the end of each transfer a completion flag is set. The flag stays set until the host clears it with a dedicated pulse. An interrupt request is raised from the two flags when interrupts are enabled.

Top module: `sshift_master`

## Requirements
- R1: After reset, `sckOut` is 1, `sdOe` is 0, `txDone`, `rxDone` and `irq` are 0, and `rxData` is 0x00.
- R2: A transmit sends the eight bits of the written byte on `sdOut`, least significant bit first, with no start or stop bits. Each bit is held for 12 system clocks, starting in the clock after the write is accepted. `sdOe` is 1 for the whole transmit.
- R3: During a transfer, each 12-clock bit time has `sckOut` low for its first 6 clocks and high for its last 6 clocks. Between transfers `sckOut` stays high.
- R4: `txDone` becomes 1 exactly 96 clocks after the clock edge that accepted the write, at the end of the eighth bit time. The engine is idle from that point.
- R5: A receive starts only while the engine is idle, `rxEnable` is 1 and `rxDone` is 0. Throughout a receive, `sdOe` is 0.
- R6: `sdIn` is sampled on the system clock edge at which `sckOut` rises. The first sample becomes bit 0 of `rxData`.
- R7: `rxDone` and the new `rxData` appear one clock after the eighth sample, which is 91 clocks after the receive started. No further receive starts until `rxDone` has been cleared.
- R8: `irq` equals `intEnable` AND (`txDone` OR `rxDone`).
- R9: A `wrEn` pulse while a transfer is in progress has no effect on the bits being sent.
- R10: `txDone` and `rxDone` are cleared only by `clrTxDone` and `clrRxDone`. When a flag is set and cleared in the same clock, the set wins.
- R11: When `wrEn` and a receive condition occur in the same idle clock, the transmit is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe that starts a transmit |
| wrData | input | 8 | Byte to transmit |
| rxEnable | input | 1 | Allows receives to start |
| intEnable | input | 1 | Enables the interrupt request |
| clrTxDone | input | 1 | Clears the transmit-complete flag |
| clrRxDone | input | 1 | Clears the receive-complete flag |
| sdIn | input | 1 | Data line input value |
| sdOut | output | 1 | Data line output value |
| sdOe | output | 1 | Data line output enable |
| sckOut | output | 1 | Shift clock output |
| rxData | output | 8 | Last received byte |
| txDone | output | 1 | Transmit-complete flag |
| rxDone | output | 1 | Receive-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The results fall due at fixed offsets from the accepting edge. Each bit leaves on `sdOut` in the clock after that edge plus 12 clocks per bit. The shift clock rises 6 clocks into every bit. `txDone` appears 96 clocks after a write, and `rxDone` with its byte 91 clocks after a receive starts. The bench keeps a behavioural model that counts clocks from each start with plain integers. It compares every output against that model half a clock after each edge. The slave data it drives is indexed by the same counter, so a sample taken on the wrong edge gives a wrong byte.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} shift_state_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic captureRx;
  } shift_strobe_t;
endpackage

// File: rtl/sshift_ctrl.sv
module sshift_ctrl
  import sshift_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic          rxEnable,
  input  logic          clrTxDone,
  input  logic          clrRxDone,
  output shift_strobe_t strb,
  output logic          sckOut,
  output logic          sdOe,
  output logic          txDone,
  output logic          rxDone
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(DATA_W);

  shift_state_t     state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic lastDiv, lastBit, startTx, startRx, txEnd, rxEnd;

  always_comb begin
    lastDiv = (divCnt == DIV_W'(CLK_DIV - 1));
    lastBit = (bitCnt == BIT_W'(DATA_W - 1));
    startTx = (state == ST_IDLE) && wrEn;
    startRx = (state == ST_IDLE) && !wrEn && rxEnable && !rxDone;
    txEnd   = (state == ST_TX) && lastBit && lastDiv;
    rxEnd   = (state == ST_RX) && lastBit && (divCnt == DIV_W'(HALF));
    strb.loadTx    = startTx;
    strb.shiftTx   = (state == ST_TX) && lastDiv;
    strb.sampleRx  = (state == ST_RX) && (divCnt == DIV_W'(HALF - 1));
    strb.captureRx = rxEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (startTx || startRx) begin
      state  <= startTx ? ST_TX : ST_RX;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (txEnd || rxEnd) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (state != ST_IDLE) begin
      divCnt <= lastDiv ? '0 : divCnt + 1'b1;
      if (lastDiv) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txDone <= 1'b0;
      rxDone <= 1'b0;
    end else begin
      if (txEnd)          txDone <= 1'b1;
      else if (clrTxDone) txDone <= 1'b0;
      if (rxEnd)          rxDone <= 1'b1;
      else if (clrRxDone) rxDone <= 1'b0;
    end
  end

  assign sckOut = (state == ST_IDLE) || (divCnt >= DIV_W'(HALF));
  assign sdOe   = (state == ST_TX);

  // R4: the last tick of the eighth transmit bit raises the flag
  a_r4_tx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && lastBit && lastDiv) |=> txDone);
  // R7: an unacknowledged receive keeps the engine idle
  a_r7_rx_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rxDone && !wrEn) |=> state == ST_IDLE);
  // R10: flags hold without a clear
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txDone && !clrTxDone) |=> txDone);
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rxDone && !clrRxDone) |=> rxDone);
  // R9: a write during a transfer does not restart it
  a_r9_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && wrEn && !lastDiv) |=> state == ST_TX && divCnt == $past(divCnt) + 1'b1);
endmodule

// File: rtl/sshift_dp.sv
module sshift_dp
  import sshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shift_strobe_t     strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdIn,
  output logic              sdOut,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] rxBuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      rxBuf    <= '0;
    end else begin
      if (strb.loadTx)        shiftReg <= wrData;
      else if (strb.shiftTx)  shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      else if (strb.sampleRx) shiftReg <= {sdIn, shiftReg[DATA_W-1:1]};
      if (strb.captureRx)     rxBuf <= shiftReg;
    end
  end

  assign sdOut  = shiftReg[0];
  assign rxData = rxBuf;

  // R6: the sampled line value enters at the top of the register
  a_r6_sample_in: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sampleRx |=> shiftReg[DATA_W-1] == $past(sdIn));
  // R2: without a strobe the shift register keeps its contents
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.loadTx || strb.shiftTx || strb.sampleRx) |=> $stable(shiftReg));
  // R7: the received byte only changes on capture
  a_r7_rxbuf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.captureRx |=> $stable(rxBuf));
endmodule

// File: rtl/sshift_master.sv
module sshift_master
  import sshift_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxEnable,
  input  logic              intEnable,
  input  logic              clrTxDone,
  input  logic              clrRxDone,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic              sckOut,
  output logic [DATA_W-1:0] rxData,
  output logic              txDone,
  output logic              rxDone,
  output logic              irq
);
  shift_strobe_t strb;

  sshift_ctrl #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rxEnable(rxEnable),
    .clrTxDone(clrTxDone), .clrRxDone(clrRxDone), .strb(strb),
    .sckOut(sckOut), .sdOe(sdOe), .txDone(txDone), .rxDone(rxDone)
  );

  sshift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .sdIn(sdIn), .sdOut(sdOut), .rxData(rxData)
  );

  assign irq = intEnable && (txDone || rxDone);

  // R5: the data line is never driven while shifting in
  a_r5_no_drive_rx: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sampleRx |-> !sdOe);
  // R3: the shift clock rises exactly when a sample is taken in receive
  a_r3_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sampleRx |=> $rose(sckOut));
endmodule

// File: tb/tb_sshift_master.sv
module tb_sshift_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 0, rst_n = 0;
  logic wrEn = 0, rxEnable = 0, intEnable = 0, clrTxDone = 0, clrRxDone = 0, sdIn = 1;
  logic [7:0] wrData = 0;
  logic sdOut, sdOe, sckOut, txDone, rxDone, irq;
  logic [7:0] rxData;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference state
  bit   mBusy, mTx, mTxDone, mRxDone;
  int   mT;
  logic [7:0] mTxByte, mRxBits, mRxData, slaveByte = 8'h00, seenTx;

  always #(CLK_PERIOD/2) clk = ~clk;

  sshift_master dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .rxEnable(rxEnable),
    .intEnable(intEnable), .clrTxDone(clrTxDone), .clrRxDone(clrRxDone), .sdIn(sdIn),
    .sdOut(sdOut), .sdOe(sdOe), .sckOut(sckOut), .rxData(rxData),
    .txDone(txDone), .rxDone(rxDone), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mBusy = 0; mTx = 0; mT = 0; mTxDone = 0; mRxDone = 0;
      mTxByte = 0; mRxBits = 0; mRxData = 0;
    end else begin
      bit endTx, endRx;
      endTx = mBusy && mTx && mT == 95;
      endRx = mBusy && !mTx && mT == 90;
      if (mBusy && !mTx && mT % 12 == 5) mRxBits[mT/12] = sdIn;
      if (mBusy && mTx && mT % 12 == 5) seenTx[mT/12] = sdOut;
      if (clrTxDone) mTxDone = 0;
      if (clrRxDone) mRxDone = 0;
      if (endTx) begin mBusy = 0; mTxDone = 1; end
      else if (endRx) begin mBusy = 0; mRxDone = 1; mRxData = mRxBits; end
      else if (mBusy) mT++;
      else if (wrEn) begin mBusy = 1; mTx = 1; mT = 0; mTxByte = wrData; end
      else if (rxEnable && !(mRxDone_prev)) begin mBusy = 1; mTx = 0; mT = 0; end
    end
  end

  // flag value seen by the start condition is the one before this edge
  bit mRxDone_prev;
  always @(negedge clk) mRxDone_prev = mRxDone;

  always @(negedge clk) begin
    sdIn <= (mBusy && !mTx) ? slaveByte[mT/12] : 1'b1;
    if (rst_n && !finished) begin
      chk("R3 sckOut", sckOut, mBusy ? int'(mT % 12 >= 6) : 1);
      chk("R5 sdOe", sdOe, int'(mBusy && mTx));
      if (mBusy && mTx) chk("R2 sdOut", sdOut, mTxByte[mT/12]);
      chk("R4 txDone", txDone, mTxDone);
      chk("R7 rxDone", rxDone, mRxDone);
      chk("R6 rxData", rxData, mRxData);
      chk("R8 irq", irq, int'(intEnable && (mTxDone || mRxDone)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    mRxDone_prev = 0;
    step(3);
    chk("R1 sckOut", sckOut, 1); chk("R1 sdOe", sdOe, 0);
    chk("R1 txDone", txDone, 0); chk("R1 rxDone", rxDone, 0);
    chk("R1 irq", irq, 0);       chk("R1 rxData", rxData, 0);
    rst_n = 1; intEnable = 1;
    step(2);
    // R5: no receive without enable
    step(20);
    chk("R5 idle clock", sckOut, 1);
    // transmit with an ignored write in the middle (R2, R9)
    wrEn = 1; wrData = 8'hA5; step(1); wrEn = 0;
    step(20);
    wrEn = 1; wrData = 8'h3C; step(1); wrEn = 0;
    step(90);
    chk("R9 sent byte", seenTx, 8'hA5);
    chk("R8 irq on txDone", irq, 1);
    intEnable = 0; step(1);
    chk("R8 irq masked", irq, 0);
    intEnable = 1;
    clrTxDone = 1; step(1); clrTxDone = 0;
    // receive (R6, R7)
    slaveByte = 8'h6B; rxEnable = 1;
    step(100);
    chk("R6 first byte", rxData, 8'h6B);
    step(30);
    chk("R7 interlock sdOe", sdOe, 0);
    chk("R7 interlock sck", sckOut, 1);
    slaveByte = 8'hC4;
    clrRxDone = 1; step(1); clrRxDone = 0;
    step(100);
    chk("R6 second byte", rxData, 8'hC4);
    rxEnable = 0;
    clrRxDone = 1; step(1); clrRxDone = 0;
    step(2);
    // R11 priority and R10 set-wins with clear held
    clrTxDone = 1; rxEnable = 1; wrEn = 1; wrData = 8'h5A;
    step(1); wrEn = 0; rxEnable = 0;
    step(2);
    chk("R11 transmit chosen", sdOe, 1);
    step(100);
    chk("R10 clear held", txDone, 0);
    clrTxDone = 0;
    step(5);
    chk("R10 stays clear", txDone, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule